// File: doc/BRIEF.md
# Configuration Stream Header Stripper

This block sits on the byte path that carries a raw configuration file toward a serialiser. The file arrives one byte per transfer on a valid/ready input. The block drops everything in front of the configuration payload. It forwards only the payload on a valid/ready output, with a last flag on the final byte. Nothing is ever emitted from the header.

The front of the file is located in two stages. First a fixed prefix is skipped. Then a chain of length-prefixed header fields is walked, where each length byte tells the block how far away the next field begins. After the final field, the block scans byte by byte for a run of sync bytes (four bytes of 0xFF by default). The run itself belongs to the payload.

Once the run is complete, the block does three things. It pulses a start indication. It latches the byte offset of the first sync byte, and that offset stays readable. It counts payload bytes as they leave. A file that ends before any run is found raises a sticky no-preamble flag instead. After the last byte of any file, the block is ready for the next file, whose byte numbering restarts at zero.

States: `ST_SKIP` drops the fixed prefix. `ST_LEN` takes a field's length byte. `ST_FIELD` drops the remaining bytes of that field. `ST_SCAN` hunts for the sync run. `ST_FLUSH` replays the sync bytes. `ST_PASS` forwards the rest of the file.

Transitions:
- SKIP→LEN: the prefix is used up.
- LEN→FIELD: always.
- FIELD→LEN: a field ends and more fields remain.
- FIELD→SCAN: the last field ends.
- SCAN→FLUSH: the run completes.
- FLUSH→PASS: the replay finishes and the file goes on.
- FLUSH→SKIP: the replay finishes and the run was the end of the file.
- PASS→SKIP: the last byte is forwarded.
- SKIP/LEN/FIELD/SCAN→SKIP: a last byte arrives early (error).

Top module: `hdr_strip_top`

## Requirements
- R1: Bytes 0 to 14 of a file are dropped. The byte at offset 15 is the length L of the first header field. The next field's length byte sits L+3 bytes further on. After four fields the scan begins at the byte that would hold a fifth length. Any value inside the header, 0xFF included, has no effect.
- R2: The scan looks for four consecutive 0xFF bytes. A non-0xFF byte restarts the count. The payload starts at the first byte of the earliest complete run, so in a run of five 0xFF bytes it starts at the first of them.
- R3: The four 0xFF sync bytes are output first. Then every later input byte is output in order. `out_last` is 1 on exactly the final byte of the file.
- R4: While a file is before its payload, `in_ready` is 1 and `out_valid` stays 0. `out_valid` is only ever 1 while `start_found` is 1.
- R5: `payload_start` is a one-cycle pulse in the cycle the first sync byte is offered on the output. `start_found` then stays 1 until the first byte of the next file is accepted.
- R6: `start_offset` holds the zero-based file offset of the first sync byte. It changes only in a cycle where `payload_start` is 1.
- R7: `payload_count` rises by one for each output transfer and is cleared when a new file begins. `payload_end` pulses in the cycle after the transfer carrying `out_last`.
- R8: If a byte with `in_last` is accepted before a run is found, `no_preamble` goes to 1 and nothing is output. The flag clears when the next file's first byte is accepted, and that file is parsed from offset 0.
- R9: Whenever `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0. No byte is lost or repeated under back-pressure.
- R10: After reset, `out_valid`, `start_found`, `no_preamble` and `payload_count` are 0, and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| in_data | input | 8 | File byte |
| in_valid | input | 1 | In_data holds a byte |
| in_last | input | 1 | The byte is the file's final byte |
| in_ready | output | 1 | The block accepts the byte |
| out_data | output | 8 | Payload byte |
| out_valid | output | 1 | Out_data holds a payload byte |
| out_last | output | 1 | Final payload byte |
| out_ready | input | 1 | Downstream accepts the byte |
| payload_start | output | 1 | Pulse on the first sync byte offered |
| start_found | output | 1 | A run was found in the current file |
| start_offset | output | 32 | Offset of the first sync byte |
| payload_count | output | 32 | Payload bytes sent in this file |
| payload_end | output | 1 | Pulse after the last payload transfer |
| no_preamble | output | 1 | File ended without a run |

## Verification
The bench fills header fields and the fixed prefix with 0xFF. A stripper that scanned too early would then lock onto the header and report a wrong offset. It also feeds broken runs and a five-byte run, which catch a run counter that fails to clear or that points at the last sync byte instead of the first. Some files end inside the header, inside a three-byte run, or exactly on the fourth sync byte. These expose a missing error flag, a lost `out_last` during the replay, and a next file that is parsed from a stale offset. Random back-pressure on the output catches dropped or duplicated bytes at the replay-to-pass hand-over.

// File: rtl/strip_pkg.sv
package strip_pkg;

    typedef enum logic [2:0] {
        ST_SKIP  = 3'd0,
        ST_LEN   = 3'd1,
        ST_FIELD = 3'd2,
        ST_SCAN  = 3'd3,
        ST_FLUSH = 3'd4,
        ST_PASS  = 3'd5
    } strip_state_t;

endpackage

// File: rtl/strip_byte_pos.sv
// Offset of the next input byte within the current file.
module strip_byte_pos #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             clear,
    output logic [CNT_W-1:0] pos
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos <= '0;
        end else if (clear) begin
            pos <= '0;
        end else if (step) begin
            pos <= pos + CNT_W'(1);
        end
    end
endmodule

// File: rtl/strip_run_det.sv
// Counts consecutive sync bytes and flags the byte that completes a run.
module strip_run_det #(
    parameter int         RUN_LEN  = 4,
    parameter logic [7:0] RUN_BYTE = 8'hFF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       en,
    input  logic [7:0] data,
    output logic       hit
);
    localparam int RUN_W = $clog2(RUN_LEN + 1);

    logic [RUN_W-1:0] run_q;
    logic             is_sync;

    assign is_sync = (data == RUN_BYTE);
    assign hit     = en && is_sync && (run_q == RUN_W'(RUN_LEN - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (clr) begin
            run_q <= '0;
        end else if (en) begin
            if (!is_sync || hit) begin
                run_q <= '0;
            end else begin
                run_q <= run_q + RUN_W'(1);
            end
        end
    end
endmodule

// File: rtl/strip_pay_cnt.sv
// Payload byte counter and end-of-payload pulse.
module strip_pay_cnt #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic             fin,
    output logic [CNT_W-1:0] count,
    output logic             end_pulse
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count     <= '0;
            end_pulse <= 1'b0;
        end else begin
            end_pulse <= inc && fin;
            if (clr) begin
                count <= '0;
            end else if (inc) begin
                count <= count + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/hdr_strip_top.sv
module hdr_strip_top #(
    parameter int         HDR_OFFSET = 15,
    parameter int         NUM_FIELDS = 4,
    parameter int         FIELD_GAP  = 3,
    parameter int         PRE_LEN    = 4,
    parameter logic [7:0] PRE_BYTE   = 8'hFF,
    parameter int         CNT_W      = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       in_data,
    input  logic             in_valid,
    input  logic             in_last,
    output logic             in_ready,
    output logic [7:0]       out_data,
    output logic             out_valid,
    output logic             out_last,
    input  logic             out_ready,
    output logic             payload_start,
    output logic             start_found,
    output logic [CNT_W-1:0] start_offset,
    output logic [CNT_W-1:0] payload_count,
    output logic             payload_end,
    output logic             no_preamble
);
    import strip_pkg::*;

    localparam int FLD_W = $clog2(NUM_FIELDS + 1);
    localparam int REM_W = $clog2(256 + FIELD_GAP);
    localparam int FLS_W = $clog2(PRE_LEN + 1);

    strip_state_t     state_q, state_d;
    logic [FLD_W-1:0] field_q, field_d;
    logic [REM_W-1:0] rem_q, rem_d;
    logic [FLS_W-1:0] flush_q, flush_d;
    logic             pend_last_q, pend_last_d;

    logic             in_acc, out_acc;
    logic [CNT_W-1:0] pos;
    logic             hit;
    logic             file_begin;
    logic             err_now;
    logic             flush_end;

    assign in_acc     = in_valid && in_ready;
    assign out_acc    = out_valid && out_ready;
    assign file_begin = in_acc && (state_q == ST_SKIP) && (pos == '0);
    assign flush_end  = (flush_q == FLS_W'(PRE_LEN - 1));

    strip_byte_pos #(.CNT_W(CNT_W)) u_pos (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (in_acc),
        .clear (in_acc && in_last),
        .pos   (pos)
    );

    strip_run_det #(.RUN_LEN(PRE_LEN), .RUN_BYTE(PRE_BYTE)) u_run (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_q != ST_SCAN),
        .en    (in_acc && (state_q == ST_SCAN)),
        .data  (in_data),
        .hit   (hit)
    );

    strip_pay_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (file_begin),
        .inc       (out_acc),
        .fin       (out_last),
        .count     (payload_count),
        .end_pulse (payload_end)
    );

    assign err_now = in_acc && in_last && !hit &&
                     (state_q inside {ST_SKIP, ST_LEN, ST_FIELD, ST_SCAN});

    // Next-state logic
    always_comb begin
        state_d     = state_q;
        field_d     = field_q;
        rem_d       = rem_q;
        flush_d     = flush_q;
        pend_last_d = pend_last_q;
        unique case (state_q)
            ST_SKIP: begin
                if (in_acc) begin
                    if (in_last) begin
                        state_d = ST_SKIP;
                    end else if (pos == CNT_W'(HDR_OFFSET - 1)) begin
                        state_d = ST_LEN;
                        field_d = '0;
                    end
                end
            end
            ST_LEN: begin
                if (in_acc) begin
                    if (in_last) begin
                        state_d = ST_SKIP;
                    end else begin
                        rem_d   = REM_W'(in_data) + REM_W'(FIELD_GAP - 1);
                        state_d = ST_FIELD;
                    end
                end
            end
            ST_FIELD: begin
                if (in_acc) begin
                    rem_d = rem_q - REM_W'(1);
                    if (in_last) begin
                        state_d = ST_SKIP;
                    end else if (rem_q == REM_W'(1)) begin
                        if (field_q == FLD_W'(NUM_FIELDS - 1)) begin
                            state_d = ST_SCAN;
                        end else begin
                            field_d = field_q + FLD_W'(1);
                            state_d = ST_LEN;
                        end
                    end
                end
            end
            ST_SCAN: begin
                if (in_acc) begin
                    if (hit) begin
                        state_d     = ST_FLUSH;
                        flush_d     = '0;
                        pend_last_d = in_last;
                    end else if (in_last) begin
                        state_d = ST_SKIP;
                    end
                end
            end
            ST_FLUSH: begin
                if (out_acc) begin
                    flush_d = flush_q + FLS_W'(1);
                    if (flush_end) begin
                        state_d = pend_last_q ? ST_SKIP : ST_PASS;
                    end
                end
            end
            ST_PASS: begin
                if (out_acc && in_last) begin
                    state_d = ST_SKIP;
                end
            end
            default: state_d = ST_SKIP;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_SKIP;
            field_q     <= '0;
            rem_q       <= '0;
            flush_q     <= '0;
            pend_last_q <= 1'b0;
        end else begin
            state_q     <= state_d;
            field_q     <= field_d;
            rem_q       <= rem_d;
            flush_q     <= flush_d;
            pend_last_q <= pend_last_d;
        end
    end

    // Stream outputs
    always_comb begin
        in_ready  = 1'b1;
        out_valid = 1'b0;
        out_data  = in_data;
        out_last  = 1'b0;
        unique case (state_q)
            ST_SKIP, ST_LEN, ST_FIELD, ST_SCAN: begin
                in_ready = 1'b1;
            end
            ST_FLUSH: begin
                in_ready  = 1'b0;
                out_valid = 1'b1;
                out_data  = PRE_BYTE;
                out_last  = pend_last_q && flush_end;
            end
            ST_PASS: begin
                in_ready  = out_ready;
                out_valid = in_valid;
                out_data  = in_data;
                out_last  = in_last;
            end
            default: in_ready = 1'b1;
        endcase
    end

    // Status flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            payload_start <= 1'b0;
            start_found   <= 1'b0;
            start_offset  <= '0;
            no_preamble   <= 1'b0;
        end else begin
            payload_start <= hit;
            if (hit) begin
                start_found  <= 1'b1;
                start_offset <= pos - CNT_W'(PRE_LEN - 1);
            end else if (file_begin) begin
                start_found <= 1'b0;
            end
            if (err_now) begin
                no_preamble <= 1'b1;
            end else if (file_begin) begin
                no_preamble <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/strip_checker.sv
module strip_checker #(
    parameter int         CNT_W    = 32,
    parameter logic [7:0] PRE_BYTE = 8'hFF
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_ready,
    input logic [7:0]       out_data,
    input logic             out_valid,
    input logic             out_last,
    input logic             out_ready,
    input logic             payload_start,
    input logic             start_found,
    input logic [CNT_W-1:0] start_offset,
    input logic [CNT_W-1:0] payload_count,
    input logic             payload_end,
    input logic             no_preamble
);
    assert_out_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> start_found);

    assert_first_beat_R5: assert property (@(posedge clk) disable iff (!rst_n)
        payload_start |-> (out_valid && out_data == PRE_BYTE));

    assert_start_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        payload_start |=> !payload_start);

    assert_offset_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(start_offset) |-> payload_start);

    assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |=> payload_count == $past(payload_count) + CNT_W'(1));

    assert_end_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> payload_end);

    assert_err_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(no_preamble && start_found));

    assert_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);
endmodule

bind hdr_strip_top strip_checker #(.CNT_W(CNT_W), .PRE_BYTE(PRE_BYTE)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_ready      (in_ready),
    .out_data      (out_data),
    .out_valid     (out_valid),
    .out_last      (out_last),
    .out_ready     (out_ready),
    .payload_start (payload_start),
    .start_found   (start_found),
    .start_offset  (start_offset),
    .payload_count (payload_count),
    .payload_end   (payload_end),
    .no_preamble   (no_preamble)
);

// File: tb/test_hdr_strip_top.sv
module test_hdr_strip_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        in_valid = 1'b0;
    logic        in_last = 1'b0;
    logic        in_ready;
    logic [7:0]  out_data;
    logic        out_valid;
    logic        out_last;
    logic        out_ready = 1'b1;
    logic        payload_start;
    logic        start_found;
    logic [31:0] start_offset;
    logic [31:0] payload_count;
    logic        payload_end;
    logic        no_preamble;

    int tests = 0;
    int fails = 0;
    int n_start = 0;
    int n_end = 0;
    logic [7:0] lfsr = 8'h5A;
    logic [7:0] fbuf[$];
    logic [8:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    hdr_strip_top i_hdr_strip_top (
        .clk(clk), .rst_n(rst_n),
        .in_data(in_data), .in_valid(in_valid), .in_last(in_last), .in_ready(in_ready),
        .out_data(out_data), .out_valid(out_valid), .out_last(out_last), .out_ready(out_ready),
        .payload_start(payload_start), .start_found(start_found),
        .start_offset(start_offset), .payload_count(payload_count),
        .payload_end(payload_end), .no_preamble(no_preamble)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Back-pressure pattern
    bit bp_on = 1'b0;
    always @(posedge clk) begin
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        out_ready <= bp_on ? (lfsr[1:0] != 2'b00) : 1'b1;
    end

    // Monitor / scoreboard
    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4 unexpected output", out_data, -1);
                end else begin
                    logic [8:0] e;
                    e = exp_q.pop_front();
                    check(out_data == e[7:0], "R3 data", out_data, e[7:0]);
                    check(out_last == e[8], "R3 last", out_last, e[8]);
                end
            end
            if (payload_start) begin
                n_start++;
                check(out_valid && out_data == 8'hFF, "R5 first beat", out_data, 255);
            end
            if (payload_end) n_end++;
            if (out_valid && !out_ready)
                check(!in_ready, "R9 stall", in_ready, 0);
        end
    end

    task automatic send_byte(input logic [7:0] b, input bit last);
        @(negedge clk);
        in_valid = 1'b1; in_data = b; in_last = last;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
    endtask

    task automatic add_header(input int l0, input int l1, input int l2, input int l3);
        int lens[4];
        lens = '{l0, l1, l2, l3};
        fbuf.delete();
        for (int i = 0; i < 15; i++) fbuf.push_back((i % 3 == 0) ? 8'hFF : 8'(i));
        for (int f = 0; f < 4; f++) begin
            fbuf.push_back(8'(lens[f]));
            for (int k = 0; k < lens[f] + 2; k++) fbuf.push_back(8'hFF);
        end
    endtask

    // Reference walk per R1/R2, then feed and check
    task automatic run_file(input string name);
        int idx = 15;
        int off = -1;
        int sz;
        sz = fbuf.size();
        for (int f = 0; f < 4 && idx < sz; f++) idx = idx + int'(fbuf[idx]) + 3;
        for (int i = idx; i + 3 < sz && off < 0; i++)
            if (fbuf[i] == 8'hFF && fbuf[i+1] == 8'hFF && fbuf[i+2] == 8'hFF && fbuf[i+3] == 8'hFF)
                off = i;
        if (off >= 0)
            for (int i = off; i < sz; i++) exp_q.push_back({(i == sz - 1), fbuf[i]});
        n_start = 0; n_end = 0;
        for (int i = 0; i < sz; i++) send_byte(fbuf[i], i == sz - 1);
        for (int w = 0; w < 2000 && exp_q.size() != 0; w++) @(negedge clk);
        repeat (4) @(negedge clk);
        #3;
        check(exp_q.size() == 0, "R3 drained", exp_q.size(), 0);
        check(start_found == (off >= 0), "R5 found", start_found, off >= 0);
        check(n_start == (off >= 0 ? 1 : 0), "R5 pulse count", n_start, off >= 0);
        check(no_preamble == (off < 0), "R8 flag", no_preamble, off < 0);
        if (off >= 0) begin
            check(start_offset == 32'(off), "R6 offset", start_offset, off);
            check(payload_count == 32'(sz - off), "R7 count", payload_count, sz - off);
            check(n_end == 1, "R7 end pulse", n_end, 1);
        end else begin
            check(payload_count == 0, "R7 count none", payload_count, 0);
        end
        exp_q.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #3;
        check(!out_valid, "R10 out_valid", out_valid, 0);
        check(in_ready, "R10 in_ready", in_ready, 1);
        check(!start_found && !no_preamble, "R10 flags", {start_found, no_preamble}, 0);
        check(payload_count == 0, "R10 count", payload_count, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 R2: FF-filled header, broken run before preamble
        add_header(2, 3, 0, 5);
        foreach (fbuf[i]) ;
        fbuf.push_back(8'h00); fbuf.push_back(8'h12); fbuf.push_back(8'hFF);
        fbuf.push_back(8'hFF); fbuf.push_back(8'h00);
        repeat (4) fbuf.push_back(8'hFF);
        for (int i = 0; i < 10; i++) fbuf.push_back(8'(i * 7 + 1));
        run_file("basic");

        // R2: overlapping run of five
        bp_on = 1'b1;
        add_header(1, 1, 1, 1);
        fbuf.push_back(8'hFF); fbuf.push_back(8'hFF); fbuf.push_back(8'hFF); fbuf.push_back(8'h3C);
        repeat (5) fbuf.push_back(8'hFF);
        fbuf.push_back(8'h81); fbuf.push_back(8'hFF); fbuf.push_back(8'h00);
        run_file("overlap");

        // R8: three-byte run then end
        add_header(4, 0, 2, 1);
        fbuf.push_back(8'hFF); fbuf.push_back(8'hFF); fbuf.push_back(8'hFF); fbuf.push_back(8'h00);
        repeat (3) fbuf.push_back(8'hFF);
        run_file("no run");

        // R3: file ends on the fourth sync byte
        add_header(0, 0, 0, 0);
        fbuf.push_back(8'h01);
        repeat (4) fbuf.push_back(8'hFF);
        run_file("run at end");

        // R8 R1: file ends inside the header
        fbuf.delete();
        for (int i = 0; i < 10; i++) fbuf.push_back(8'hFF);
        run_file("short");

        // R9 R7: long fields and payload under back-pressure
        add_header(200, 7, 30, 3);
        fbuf.push_back(8'h44);
        repeat (4) fbuf.push_back(8'hFF);
        for (int i = 0; i < 300; i++) fbuf.push_back(8'(i ^ 8'h5A));
        run_file("long");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule